// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-facing register file for a sixteen-channel DMA controller. A processor reaches it over a simple single-cycle 32-bit register bus. The block keeps each channel's control/status word, its control-block pointer and a scratch debug word. It shows read-only copies of the fields that the channel engine is currently working on. It also keeps two global words: one interrupt-pending bit per channel and a 16-bit channel enable mask.

The channel engine sits beside this block. It receives a one-cycle start pulse when software turns a channel's ACTIVE bit on. It reports back through per-channel event strobes: block end, interrupt, run finished, and a new control-block pointer. The block merges these events into the status words and drives one interrupt output per channel from the pending bits.

Address bit 12 clear selects the main 4 KiB window. Below offset 0xF00 of that window, bits 11:8 pick the channel and bits 7:0 pick the register. Address bit 12 set selects a separate 256-byte window that always addresses channel 15.

Top module: `dma_regbank`

## Requirements
- R1: After reset, every status word, control-block pointer and debug word reads 0. The enable mask reads 0x0000FFFF, the pending word reads 0, and `irq_o`, `start_o` and `bus_rdata` are 0.
- R2: Per-channel register offsets are: status 0x00, control-block pointer 0x04, debug 0x20. Pointer and debug are read-write. A channel's registers are reached at `{1'b0, ch[3:0], offset[7:0]}` for ch < 15, and channel 15 is also reached at `{1'b1, 4'h0, offset[7:0]}`.
- R3: Offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C read the engine's info, source, destination, length, stride and next-block inputs for the addressed channel. Writes to these offsets change nothing.
- R4: A write to status takes bits 0, 16–23, 28 and 29 (mask 0x30FF0001) from the write data. Every other status bit keeps its value.
- R5: A write to status with bit 1 set clears END (bit 1). A write with bit 2 set clears INT (bit 2), clears the channel's pending bit and drops its `irq_o` line.
- R6: A write to status with bit 31 set zeroes the status word and the control-block pointer before the masked bits are applied. Bit 30 (abort) has no effect.
- R7: `start_o[c]` pulses for one cycle, one cycle after a status write that takes ACTIVE (bit 0) from 0 to 1, and only when enable bit c is set. A write that finds ACTIVE already set gives no pulse.
- R8: Offset 0xFE0 of the main window reads the pending bits in bits 15:0, and writes to it are ignored. Offset 0xFF0 reads and writes the enable mask in bits 15:0, with upper bits reading 0.
- R9: Unmapped offsets read 0 and writes to them change nothing. These are offsets 0xF00–0xFFF other than 0xFE0 and 0xFF0, per-channel offsets above 0x20, and offsets that are not word aligned.
- R10: The engine strobes act on the addressed channel:
  - end sets status bit 1;
  - interrupt sets bit 2, the pending bit and `irq_o`;
  - done clears bit 0 and sets bit 4;
  - pointer-load copies the engine's pointer into the control-block pointer unless a bus write to the pointer, or a channel reset, happens in the same cycle.
- R11: When an engine strobe and a bus write hit the same channel in the same cycle, the done strobe is applied before the write, so the write sees ACTIVE already cleared. End and interrupt sets are applied after the write's clears, so no event is lost.
- R12: `bus_rdata` is registered. It shows, one cycle after the address is presented, the register value from before any write made in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 13 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_info_i | input | 512 | Current info word per channel (32 bits each) |
| eng_src_i | input | 512 | Current source address per channel |
| eng_dst_i | input | 512 | Current destination address per channel |
| eng_len_i | input | 512 | Current transfer length per channel |
| eng_stride_i | input | 512 | Current stride per channel |
| eng_next_i | input | 512 | Current next-block pointer per channel |
| eng_end_i | input | 16 | Block-end strobe per channel |
| eng_int_i | input | 16 | Interrupt strobe per channel |
| eng_done_i | input | 16 | Run-finished strobe per channel |
| eng_cbld_i | input | 16 | Pointer-load strobe per channel |
| eng_cbaddr_i | input | 512 | Pointer value to load per channel |
| start_o | output | 16 | Start pulse per channel |
| irq_o | output | 16 | Interrupt line per channel |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the engine raising an interrupt and software clearing INT by writing a one to bit 2. The second pair is the engine finishing a run while software writes ACTIVE. The bench provokes both by driving the engine strobe and the bus write on the same clock edge. It then judges the result through the status readback, `irq_o` and `start_o`: the interrupt must stay pending, and the ACTIVE write must count as a fresh 0-to-1 edge and produce a start pulse.

// File: rtl/dma_regbank.sv
module dma_regbank #(
  parameter int NCH = 16,
  parameter int AW = 13,
  parameter int DW = 32,
  parameter logic [31:0] RW_MASK = 32'h30FF0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH*DW-1:0] eng_info_i,
  input  logic [NCH*DW-1:0] eng_src_i,
  input  logic [NCH*DW-1:0] eng_dst_i,
  input  logic [NCH*DW-1:0] eng_len_i,
  input  logic [NCH*DW-1:0] eng_stride_i,
  input  logic [NCH*DW-1:0] eng_next_i,
  input  logic [NCH-1:0]    eng_end_i,
  input  logic [NCH-1:0]    eng_int_i,
  input  logic [NCH-1:0]    eng_done_i,
  input  logic [NCH-1:0]    eng_cbld_i,
  input  logic [NCH*DW-1:0] eng_cbaddr_i,
  output logic [NCH-1:0]    start_o,
  output logic [NCH-1:0]    irq_o
);
  localparam logic [7:0] OFS_CS  = 8'h00, OFS_CB  = 8'h04, OFS_INFO = 8'h08,
                         OFS_SRC = 8'h0C, OFS_DST = 8'h10, OFS_LEN  = 8'h14,
                         OFS_STR = 8'h18, OFS_NXT = 8'h1C, OFS_DBG  = 8'h20;
  localparam logic [7:0] OFS_PEND = 8'hE0, OFS_EN = 8'hF0;

  logic [NCH*DW-1:0] cs_all, cb_all, dbg_all;
  logic [NCH-1:0] en_q, pend_q, start_q, pend_clr;

  logic       win15, glob, ch_hit;
  logic [3:0] ch;
  logic [7:0] ofs;

  assign win15  = bus_addr[12];
  assign glob   = !win15 && (bus_addr[11:8] == 4'hF);
  assign ch     = win15 ? 4'hF : bus_addr[11:8];
  assign ofs    = bus_addr[7:0];
  assign ch_hit = !glob && (int'(ch) < NCH);

  assign start_o = start_q;
  assign irq_o   = pend_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] cs_q, cb_q, dbg_q, mrg, nxt;
    logic sel, wcs;

    assign sel = bus_we && ch_hit && (int'(ch) == c);
    assign wcs = sel && (ofs == OFS_CS);

    always_comb begin
      mrg = cs_q;
      if (eng_done_i[c]) begin
        mrg[0] = 1'b0;
        mrg[4] = 1'b1;
      end
      nxt = mrg;
      if (wcs) begin
        if (bus_wdata[31]) nxt = '0;
        if (bus_wdata[1])  nxt[1] = 1'b0;
        if (bus_wdata[2])  nxt[2] = 1'b0;
        nxt = (nxt & ~RW_MASK) | (bus_wdata & RW_MASK);
      end
      if (eng_end_i[c]) nxt[1] = 1'b1;
      if (eng_int_i[c]) nxt[2] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cs_q       <= '0;
        cb_q       <= '0;
        dbg_q      <= '0;
        start_q[c] <= 1'b0;
      end else begin
        cs_q       <= nxt;
        start_q[c] <= wcs && !mrg[0] && bus_wdata[0] && en_q[c];
        if (wcs && bus_wdata[31])
          cb_q <= '0;
        else if (sel && ofs == OFS_CB)
          cb_q <= bus_wdata;
        else if (eng_cbld_i[c])
          cb_q <= eng_cbaddr_i[c*DW +: DW];
        if (sel && ofs == OFS_DBG)
          dbg_q <= bus_wdata;
      end
    end

    assign pend_clr[c]         = wcs && bus_wdata[2];
    assign cs_all[c*DW +: DW]  = cs_q;
    assign cb_all[c*DW +: DW]  = cb_q;
    assign dbg_all[c*DW +: DW] = dbg_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '1;
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~pend_clr) | eng_int_i;
      if (bus_we && glob && ofs == OFS_EN)
        en_q <= bus_wdata[NCH-1:0];
    end
  end

  logic [DW-1:0] rd;
  always_comb begin
    rd = '0;
    if (glob) begin
      if (ofs == OFS_PEND)    rd[NCH-1:0] = pend_q;
      else if (ofs == OFS_EN) rd[NCH-1:0] = en_q;
    end else if (ch_hit) begin
      case (ofs)
        OFS_CS:   rd = cs_all[int'(ch)*DW +: DW];
        OFS_CB:   rd = cb_all[int'(ch)*DW +: DW];
        OFS_INFO: rd = eng_info_i[int'(ch)*DW +: DW];
        OFS_SRC:  rd = eng_src_i[int'(ch)*DW +: DW];
        OFS_DST:  rd = eng_dst_i[int'(ch)*DW +: DW];
        OFS_LEN:  rd = eng_len_i[int'(ch)*DW +: DW];
        OFS_STR:  rd = eng_stride_i[int'(ch)*DW +: DW];
        OFS_NXT:  rd = eng_next_i[int'(ch)*DW +: DW];
        OFS_DBG:  rd = dbg_all[int'(ch)*DW +: DW];
        default:  rd = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd;
  end
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
  parameter int NCH = 16,
  parameter int AW = 13,
  parameter int DW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_we,
  input logic [DW-1:0]  bus_rdata,
  input logic [NCH-1:0] eng_int_i,
  input logic [NCH-1:0] start_o,
  input logic [NCH-1:0] irq_o
);
  logic unmapped_glob;
  assign unmapped_glob = !bus_addr[12] && bus_addr[11:8] == 4'hF &&
                         bus_addr[7:0] != 8'hE0 && bus_addr[7:0] != 8'hF0;

  assert_start_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    |start_o |-> $past(bus_we));

  assert_onehot_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_o));

  assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    |(irq_o & ~$past(irq_o)) |-> |$past(eng_int_i));

  assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    |(~irq_o & $past(irq_o)) |-> $past(bus_we));

  assert_pend_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'('h0FE0) && !(|eng_int_i)) |=> irq_o == $past(irq_o));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_glob |=> bus_rdata == '0);
endmodule

bind dma_regbank dma_regbank_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .eng_int_i(eng_int_i), .start_o(start_o), .irq_o(irq_o)
);

// File: tb/sim_dma_regbank.sv
`timescale 1ns/1ps
module sim_dma_regbank;
  localparam int NCH = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH*DW-1:0] v_info, v_src, v_dst, v_len, v_str, v_nxt;
  logic [NCH-1:0] eng_end = '0, eng_int = '0, eng_done = '0, eng_cbld = '0;
  logic [NCH*DW-1:0] eng_cbaddr = '0;
  logic [NCH-1:0] start_o, irq_o;

  int checks = 0;
  int fails = 0;
  logic [31:0] r;

  always #4 clk = ~clk;

  for (genvar c = 0; c < NCH; c++) begin : g_v
    assign v_info[c*DW +: DW] = 32'h1100_0000 | c;
    assign v_src[c*DW +: DW]  = 32'h2200_0000 | (c << 4);
    assign v_dst[c*DW +: DW]  = 32'h3300_0000 | (c << 8);
    assign v_len[c*DW +: DW]  = 32'h0000_4000 + c;
    assign v_str[c*DW +: DW]  = 32'h0055_0000 | c;
    assign v_nxt[c*DW +: DW]  = 32'h6600_0000 | (c << 12);
  end

  dma_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_info_i(v_info), .eng_src_i(v_src), .eng_dst_i(v_dst),
    .eng_len_i(v_len), .eng_stride_i(v_str), .eng_next_i(v_nxt),
    .eng_end_i(eng_end), .eng_int_i(eng_int), .eng_done_i(eng_done),
    .eng_cbld_i(eng_cbld), .eng_cbaddr_i(eng_cbaddr),
    .start_o(start_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic ev(input int c, input bit e, input bit i, input bit dn);
    @(negedge clk);
    eng_end[c] = e; eng_int[c] = i; eng_done[c] = dn;
    @(negedge clk);
    eng_end = '0; eng_int = '0; eng_done = '0;
  endtask

  task automatic t_reset();
    chk("R1 start", {16'h0, start_o}, 32'h0);
    chk("R1 irq", {16'h0, irq_o}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rd(13'h000, r); chk("R1 cs0", r, 32'h0);
    rd(13'h304, r); chk("R1 cb3", r, 32'h0);
    rd(13'h720, r); chk("R1 dbg7", r, 32'h0);
    rd(13'hFF0, r); chk("R1 enable", r, 32'h0000FFFF);
    rd(13'hFE0, r); chk("R1 pending", r, 32'h0);
  endtask

  task automatic t_decode();
    wr(13'h004, 32'hA000_0000);
    wr(13'h704, 32'hA700_0007);
    wr(13'h1004, 32'hAF00_000F);
    wr(13'h320, 32'hD300_0003);
    rd(13'h004, r); chk("R2 cb0", r, 32'hA000_0000);
    rd(13'h704, r); chk("R2 cb7", r, 32'hA700_0007);
    rd(13'h1004, r); chk("R2 cb15 window", r, 32'hAF00_000F);
    rd(13'h320, r); chk("R2 dbg3", r, 32'hD300_0003);
    rd(13'hE04, r); chk("R2 cb14 untouched", r, 32'h0);
    rd(13'h220, r); chk("R2 dbg2 untouched", r, 32'h0);
  endtask

  task automatic t_views();
    rd(13'h508, r); chk("R3 info5", r, 32'h1100_0005);
    rd(13'h50C, r); chk("R3 src5", r, 32'h2200_0050);
    rd(13'h1010, r); chk("R3 dst15", r, 32'h3300_0F00);
    rd(13'h914, r); chk("R3 len9", r, 32'h0000_4009);
    rd(13'h218, r); chk("R3 stride2", r, 32'h0055_0002);
    rd(13'h21C, r); chk("R3 next2", r, 32'h6600_2000);
    wr(13'h508, 32'hDEAD_BEEF);
    rd(13'h508, r); chk("R3 info5 after write", r, 32'h1100_0005);
  endtask

  task automatic t_mask();
    wr(13'h200, 32'h3FFF_FFFE);
    rd(13'h200, r); chk("R4 masked bits", r, 32'h30FF_0000);
    chk("R4 no start", {16'h0, start_o}, 32'h0);
    wr(13'h200, 32'h0);
    rd(13'h200, r); chk("R4 cleared", r, 32'h0);
  endtask

  task automatic t_w1c();
    ev(4, 1'b1, 1'b1, 1'b0);
    rd(13'h400, r); chk("R10 end+int set", r, 32'h6);
    chk("R10 irq4", {16'h0, irq_o}, 32'h0010);
    wr(13'h400, 32'h2);
    rd(13'h400, r); chk("R5 end cleared", r, 32'h4);
    chk("R5 irq kept", {16'h0, irq_o}, 32'h0010);
    wr(13'h400, 32'h4);
    rd(13'h400, r); chk("R5 int cleared", r, 32'h0);
    chk("R5 irq dropped", {16'h0, irq_o}, 32'h0);
    rd(13'hFE0, r); chk("R5 pending cleared", r, 32'h0);
  endtask

  task automatic t_chreset();
    wr(13'h604, 32'h0000_1234);
    wr(13'h600, 32'h0001_0000);
    ev(6, 1'b1, 1'b0, 1'b0);
    rd(13'h600, r); chk("R6 before abort", r, 32'h0001_0002);
    wr(13'h600, 32'h4001_0000);
    rd(13'h600, r); chk("R6 abort no effect", r, 32'h0001_0002);
    rd(13'h604, r); chk("R6 cb kept", r, 32'h0000_1234);
    wr(13'h600, 32'h8000_0000);
    rd(13'h600, r); chk("R6 reset cs", r, 32'h0);
    rd(13'h604, r); chk("R6 reset cb", r, 32'h0);
  endtask

  task automatic t_start();
    wr(13'h100, 32'h1);
    chk("R7 start pulse", {16'h0, start_o}, 32'h0002);
    @(negedge clk);
    chk("R7 single cycle", {16'h0, start_o}, 32'h0);
    wr(13'h100, 32'h1);
    chk("R7 no restart", {16'h0, start_o}, 32'h0);
    ev(1, 1'b0, 1'b0, 1'b1);
    rd(13'h100, r); chk("R10 done", r, 32'h10);
    wr(13'hFF0, 32'h0000_FFFD);
    wr(13'h100, 32'h1);
    chk("R7 disabled no start", {16'h0, start_o}, 32'h0);
    rd(13'h100, r); chk("R7 active kept", r, 32'h11);
    wr(13'hFF0, 32'h0000_FFFF);
    wr(13'h100, 32'h8000_0000);
  endtask

  task automatic t_global();
    ev(9, 1'b0, 1'b1, 1'b0);
    rd(13'hFE0, r); chk("R8 pending9", r, 32'h0000_0200);
    wr(13'hFE0, 32'h0);
    rd(13'hFE0, r); chk("R8 pending ro", r, 32'h0000_0200);
    chk("R8 irq9 kept", {16'h0, irq_o}, 32'h0200);
    wr(13'h900, 32'h4);
    rd(13'hFE0, r); chk("R8 pending cleared", r, 32'h0);
    wr(13'hFF0, 32'h1234_5678);
    rd(13'hFF0, r); chk("R8 enable 16b", r, 32'h0000_5678);
    wr(13'hFF0, 32'h0000_FFFF);
  endtask

  task automatic t_unmapped();
    rd(13'hF04, r); chk("R9 F04", r, 32'h0);
    rd(13'hF40, r); chk("R9 F40", r, 32'h0);
    wr(13'h024, 32'hFFFF_FFFF);
    wr(13'h001, 32'hFFFF_FFFF);
    rd(13'h024, r); chk("R9 ofs24", r, 32'h0);
    rd(13'h000, r); chk("R9 cs0 unchanged", r, 32'h0);
    rd(13'h004, r); chk("R9 cb0 unchanged", r, 32'hA000_0000);
  endtask

  task automatic t_cbload();
    @(negedge clk);
    eng_cbaddr[11*DW +: DW] = 32'h8000_0040;
    eng_cbld[11] = 1'b1;
    @(negedge clk);
    eng_cbld = '0;
    rd(13'hB04, r); chk("R10 cb load", r, 32'h8000_0040);
  endtask

  task automatic t_collide();
    ev(12, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    bus_addr = 13'hC00; bus_wdata = 32'h4; bus_we = 1'b1; eng_int[12] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; eng_int = '0;
    rd(13'hC00, r); chk("R11 int survives clear", r, 32'h4);
    chk("R11 irq12 kept", {16'h0, irq_o}, 32'h1000);
    wr(13'hC00, 32'h4);
    wr(13'hD00, 32'h1);
    chk("R11 first start13", {16'h0, start_o}, 32'h2000);
    @(negedge clk);
    bus_addr = 13'hD00; bus_wdata = 32'h1; bus_we = 1'b1; eng_done[13] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; eng_done = '0;
    chk("R11 done then restart", {16'h0, start_o}, 32'h2000);
    rd(13'hD00, r); chk("R11 cs13", r, 32'h11);
  endtask

  task automatic t_rdtiming();
    wr(13'hA04, 32'h0000_CAFE);
    chk("R12 old value in write cycle", bus_rdata, 32'h0);
    rd(13'hA04, r); chk("R12 new value", r, 32'h0000_CAFE);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_views();
    t_mask();
    t_w1c();
    t_chreset();
    t_start();
    t_global();
    t_unmapped();
    t_cbload();
    t_collide();
    t_rdtiming();
    finish_run();
  end
endmodule